// File: doc/BRIEF.md
# Two-Port Memory with Grouped Write Masks

This block is a synthesizable behavioural model of a synchronous memory with two independent access ports. Each port has its own address, write data, registered read data, chip select (active low), a write/read select (high for write) and an output enable. Both ports are sampled on the same rising clock edge. Writes are masked by group. A parameter sets how many adjacent data bits each write-enable bit covers. A group size of zero means that a single enable bit covers the whole word.

When both ports are enabled on the same edge with equal addresses, the model treats it as a collision and applies fixed rules. Two reads both succeed. A write paired with a read lets the write land, and the reading port gets all ones and raises its collision flag for one cycle. Two writes leave the stored word untouched and raise both flags. Accesses on different edges never interact. A group size that is nonzero and does not divide the data width is rejected at elaboration.

Top module: `twin_port_mask_ram`

## Requirements
- R1: A port whose chip select is high ignores its address, data, mask and write select on that edge: its read-data register keeps its value and memory is not changed by it.
- R2: With chip select low and write select low, the port's output shows the addressed word starting in the cycle after the edge.
- R3: When a port's output enable is low its data output is high impedance; when high it drives the registered read-data value.
- R4: Mask bit k writes data bits k*G through k*G+G-1 only (G the group size, e.g. 16 bits with G=4 gives four mask bits, bit 0 over bits 3:0); bits under a clear mask bit keep their old contents.
- R5: With a group size of 0 the mask is one bit wide and writes or protects the whole word.
- R6: If one port writes and the other reads the same address on the same edge, the write completes, the reading port outputs all ones, and only the reading port's collision flag is high for exactly the following cycle.
- R7: If both ports write the same address on the same edge, the stored word keeps its old value, each writing port outputs that old word, and both collision flags are high for the following cycle.
- R8: If both ports read the same address on the same edge, both return the stored word and neither flag rises.
- R9: A write cycle loads the port's output register with the word as it stands after the masked write.
- R10: Accesses to different addresses, or with one port deselected, raise no collision flag and proceed independently.
- R11: After reset both read-data registers hold zero and both collision flags are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active for both ports |
| rst_n | input | 1 | Active-low reset of output and flag registers |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_wr | input | 1 | Port A write (1) or read (0) |
| a_oe | input | 1 | Port A output enable, active high |
| a_addr | input | AW | Port A word address |
| a_wdata | input | WIDTH | Port A write data |
| a_wmask | input | NGRP | Port A per-group write enable |
| a_rdata | output | WIDTH | Port A data output, high impedance when disabled |
| a_clash | output | 1 | Port A collision flag, one-cycle pulse |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_wr | input | 1 | Port B write (1) or read (0) |
| b_oe | input | 1 | Port B output enable, active high |
| b_addr | input | AW | Port B word address |
| b_wdata | input | WIDTH | Port B write data |
| b_wmask | input | NGRP | Port B per-group write enable |
| b_rdata | output | WIDTH | Port B data output, high impedance when disabled |
| b_clash | output | 1 | Port B collision flag, one-cycle pulse |

## Verification
The bench aims at partial writes in which only some groups change, since a model that expands the mask with the wrong stride or polarity corrupts neighbouring nibbles, and at the whole-word group-size-zero variant, where a wrong mask width would write nothing or only a slice. It forces each kind of same-address collision: a model that lets the reader see the new or old word, flags the writer, keeps the flag up for more than one cycle, or lets one of two colliding writes land produces values other than all ones or the unchanged word. Deselected ports and different addresses check that a detector ignoring chip select or comparing too few address bits does not raise false flags. Output-enable checks catch an output that still drives the registered word when it should float.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
    typedef enum logic [2:0] {
        CLASH_NONE,
        CLASH_RD_RD,
        CLASH_AW_BR,
        CLASH_AR_BW,
        CLASH_WR_WR
    } clash_e;
endpackage

// File: rtl/tpm_mask_expand.sv
module tpm_mask_expand #(
    parameter int WIDTH = 16,
    parameter int GW    = 4,
    localparam int NGRP = WIDTH / GW
) (
    input  logic [NGRP-1:0]  grp_en,
    output logic [WIDTH-1:0] bit_en
);
    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        assign bit_en[k*GW +: GW] = {GW{grp_en[k]}};
    end
endmodule

// File: rtl/tpm_clash_detect.sv
module tpm_clash_detect
    import tpm_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          en_a,
    input  logic          en_b,
    input  logic          wr_a,
    input  logic          wr_b,
    input  logic [AW-1:0] addr_a,
    input  logic [AW-1:0] addr_b,
    output clash_e        kind
);
    always_comb begin
        kind = CLASH_NONE;
        if (en_a && en_b && (addr_a == addr_b)) begin
            unique case ({wr_a, wr_b})
                2'b00:   kind = CLASH_RD_RD;
                2'b10:   kind = CLASH_AW_BR;
                2'b01:   kind = CLASH_AR_BW;
                default: kind = CLASH_WR_WR;
            endcase
        end
    end
endmodule

// File: rtl/tpm_ram_core.sv
module tpm_ram_core #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we_a,
    input  logic [AW-1:0]    addr_a,
    input  logic [WIDTH-1:0] bits_a,
    input  logic [WIDTH-1:0] wdata_a,
    input  logic             we_b,
    input  logic [AW-1:0]    addr_b,
    input  logic [WIDTH-1:0] bits_b,
    input  logic [WIDTH-1:0] wdata_b,
    output logic [WIDTH-1:0] word_a,
    output logic [WIDTH-1:0] word_b
);
    logic [WIDTH-1:0] cells [DEPTH];

    assign word_a = cells[addr_a];
    assign word_b = cells[addr_b];

    always_ff @(posedge clk) begin
        if (we_a) cells[addr_a] <= (cells[addr_a] & ~bits_a) | (wdata_a & bits_a);
        if (we_b) cells[addr_b] <= (cells[addr_b] & ~bits_b) | (wdata_b & bits_b);
    end
endmodule

// File: rtl/twin_port_mask_ram.sv
module twin_port_mask_ram
    import tpm_pkg::*;
#(
    parameter int WIDTH  = 16,
    parameter int DEPTH  = 32,
    parameter int GROUP  = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int GW    = (GROUP == 0) ? WIDTH : GROUP,
    localparam int NGRP  = WIDTH / GW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_cs_n,
    input  logic             a_wr,
    input  logic             a_oe,
    input  logic [AW-1:0]    a_addr,
    input  logic [WIDTH-1:0] a_wdata,
    input  logic [NGRP-1:0]  a_wmask,
    output logic [WIDTH-1:0] a_rdata,
    output logic             a_clash,
    input  logic             b_cs_n,
    input  logic             b_wr,
    input  logic             b_oe,
    input  logic [AW-1:0]    b_addr,
    input  logic [WIDTH-1:0] b_wdata,
    input  logic [NGRP-1:0]  b_wmask,
    output logic [WIDTH-1:0] b_rdata,
    output logic             b_clash
);
    if (GROUP != 0 && (WIDTH % GROUP) != 0) begin : g_bad_group
        $error("group size must divide the data width");
    end

    typedef struct packed {
        logic [WIDTH-1:0] a_dout;
        logic [WIDTH-1:0] b_dout;
        logic             a_flag;
        logic             b_flag;
    } regs_t;

    regs_t r_d, r_q;

    logic             en_a, en_b, we_a, we_b;
    logic [WIDTH-1:0] bits_a, bits_b, word_a, word_b, merged_a, merged_b;
    clash_e           kind;

    assign en_a = !a_cs_n;
    assign en_b = !b_cs_n;

    tpm_mask_expand #(.WIDTH(WIDTH), .GW(GW)) u_mask_a (.grp_en(a_wmask), .bit_en(bits_a));
    tpm_mask_expand #(.WIDTH(WIDTH), .GW(GW)) u_mask_b (.grp_en(b_wmask), .bit_en(bits_b));

    tpm_clash_detect #(.AW(AW)) u_clash (
        .en_a(en_a), .en_b(en_b), .wr_a(a_wr), .wr_b(b_wr),
        .addr_a(a_addr), .addr_b(b_addr), .kind(kind)
    );

    assign we_a = en_a && a_wr && (kind != CLASH_WR_WR);
    assign we_b = en_b && b_wr && (kind != CLASH_WR_WR);

    tpm_ram_core #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_core (
        .clk(clk),
        .we_a(we_a), .addr_a(a_addr), .bits_a(bits_a), .wdata_a(a_wdata),
        .we_b(we_b), .addr_b(b_addr), .bits_b(bits_b), .wdata_b(b_wdata),
        .word_a(word_a), .word_b(word_b)
    );

    assign merged_a = (word_a & ~bits_a) | (a_wdata & bits_a);
    assign merged_b = (word_b & ~bits_b) | (b_wdata & bits_b);

    always_comb begin
        r_d        = r_q;
        r_d.a_flag = (kind == CLASH_WR_WR) || (kind == CLASH_AR_BW);
        r_d.b_flag = (kind == CLASH_WR_WR) || (kind == CLASH_AW_BR);
        if (en_a) begin
            if (a_wr)                    r_d.a_dout = (kind == CLASH_WR_WR) ? word_a : merged_a;
            else if (kind == CLASH_AR_BW) r_d.a_dout = '1;
            else                          r_d.a_dout = word_a;
        end
        if (en_b) begin
            if (b_wr)                    r_d.b_dout = (kind == CLASH_WR_WR) ? word_b : merged_b;
            else if (kind == CLASH_AW_BR) r_d.b_dout = '1;
            else                          r_d.b_dout = word_b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign a_rdata = a_oe ? r_q.a_dout : 'z;
    assign b_rdata = b_oe ? r_q.b_dout : 'z;
    assign a_clash = r_q.a_flag;
    assign b_clash = r_q.b_flag;
endmodule

module twin_port_mask_ram_chk #(
    parameter int WIDTH = 16,
    parameter int AW    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             a_cs_n,
    input logic             b_cs_n,
    input logic             a_wr,
    input logic             b_wr,
    input logic [AW-1:0]    a_addr,
    input logic [AW-1:0]    b_addr,
    input logic [WIDTH-1:0] a_q,
    input logic [WIDTH-1:0] b_q,
    input logic             a_clash,
    input logic             b_clash
);
    logic same_edge;
    assign same_edge = !a_cs_n && !b_cs_n && (a_addr == b_addr);

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        a_cs_n |=> $stable(a_q)); // R1

    AST_WR_RD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (same_edge && a_wr && !b_wr) |=> (b_q == '1 && b_clash && !a_clash)); // R6

    AST_WR_WR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (same_edge && a_wr && b_wr) |=> (a_clash && b_clash)); // R7

    AST_RD_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (same_edge && !a_wr && !b_wr) |=> (!a_clash && !b_clash)); // R8

    AST_NO_FALSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !same_edge |=> (!a_clash && !b_clash)); // R10
endmodule

bind twin_port_mask_ram twin_port_mask_ram_chk #(.WIDTH(WIDTH), .AW(AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .a_cs_n(a_cs_n), .b_cs_n(b_cs_n),
    .a_wr(a_wr), .b_wr(b_wr), .a_addr(a_addr), .b_addr(b_addr),
    .a_q(r_q.a_dout), .b_q(r_q.b_dout), .a_clash(a_clash), .b_clash(b_clash)
);

// File: tb/twin_port_mask_ram_tb_top.sv
module twin_port_mask_ram_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        a_cs_n, a_wr, a_oe, b_cs_n, b_wr, b_oe;
    logic [4:0]  a_addr, b_addr;
    logic [15:0] a_wd, b_wd;
    logic [3:0]  a_wm, b_wm;
    tri1  [15:0] a_bus, b_bus, g_a_bus, g_b_bus;
    logic        a_cl, b_cl, g_a_cl, g_b_cl;

    int n_tests = 0;
    int n_fail  = 0;

    twin_port_mask_ram #(.WIDTH(16), .DEPTH(32), .GROUP(4)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_cs_n(a_cs_n), .a_wr(a_wr), .a_oe(a_oe), .a_addr(a_addr),
        .a_wdata(a_wd), .a_wmask(a_wm), .a_rdata(a_bus), .a_clash(a_cl),
        .b_cs_n(b_cs_n), .b_wr(b_wr), .b_oe(b_oe), .b_addr(b_addr),
        .b_wdata(b_wd), .b_wmask(b_wm), .b_rdata(b_bus), .b_clash(b_cl)
    );

    twin_port_mask_ram #(.WIDTH(16), .DEPTH(32), .GROUP(0)) dut_w_i (
        .clk(clk), .rst_n(rst_n),
        .a_cs_n(a_cs_n), .a_wr(a_wr), .a_oe(a_oe), .a_addr(a_addr),
        .a_wdata(a_wd), .a_wmask(a_wm[0]), .a_rdata(g_a_bus), .a_clash(g_a_cl),
        .b_cs_n(b_cs_n), .b_wr(b_wr), .b_oe(b_oe), .b_addr(b_addr),
        .b_wdata(b_wd), .b_wmask(b_wm[0]), .b_rdata(g_b_bus), .b_clash(g_b_cl)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        a_cs_n = 1; a_wr = 0; a_oe = 1; a_addr = '0; a_wd = '0; a_wm = '0;
        b_cs_n = 1; b_wr = 0; b_oe = 1; b_addr = '0; b_wd = '0; b_wm = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic put_a(input logic wr, input logic [4:0] ad, input logic [15:0] d, input logic [3:0] m);
        a_cs_n = 0; a_wr = wr; a_addr = ad; a_wd = d; a_wm = m;
    endtask

    task automatic put_b(input logic wr, input logic [4:0] ad, input logic [15:0] d, input logic [3:0] m);
        b_cs_n = 0; b_wr = wr; b_addr = ad; b_wd = d; b_wm = m;
    endtask

    task automatic t_reset();
        chk("R11 a out", a_bus, 16'h0000);
        chk("R11 b out", b_bus, 16'h0000);
        chk("R11 flags", {a_cl, b_cl}, 2'b00);
    endtask

    task automatic t_write_read();
        idle(); put_a(1, 5'd3, 16'h1234, 4'hF); tick();
        chk("R9 write shows word", a_bus, 16'h1234);
        idle(); put_b(0, 5'd3, 16'h0000, 4'h0); tick();
        chk("R2 read port B", b_bus, 16'h1234);
    endtask

    task automatic t_mask();
        idle(); put_a(1, 5'd5, 16'hAAAA, 4'hF); tick();
        idle(); put_a(1, 5'd5, 16'h5555, 4'b0101); tick();
        chk("R4 R9 merged on write", a_bus, 16'hA5A5);
        idle(); put_b(0, 5'd5, 16'h0000, 4'h0); tick();
        chk("R4 merged stored", b_bus, 16'hA5A5);
    endtask

    task automatic t_idle();
        idle();
        a_wr = 1; a_addr = 5'd5; a_wd = 16'h0000; a_wm = 4'hF;
        tick();
        chk("R1 deselected output holds", a_bus, 16'hA5A5);
        idle(); put_b(0, 5'd5, 16'h0000, 4'h0); tick();
        chk("R1 deselected no write", b_bus, 16'hA5A5);
    endtask

    task automatic t_oe();
        idle(); a_oe = 0; #1;
        chk("R3 output floats", a_bus, 16'hFFFF);
        a_oe = 1; #1;
        chk("R3 output drives", a_bus, 16'hA5A5);
    endtask

    task automatic t_wr_clash();
        idle(); put_a(1, 5'd7, 16'h0F0F, 4'hF); put_b(0, 5'd7, 16'h0000, 4'h0); tick();
        chk("R6 writer output", a_bus, 16'h0F0F);
        chk("R6 reader ones", b_bus, 16'hFFFF);
        chk("R6 flags", {a_cl, b_cl}, 2'b01);
        idle(); put_b(0, 5'd7, 16'h0000, 4'h0); tick();
        chk("R6 flag one cycle", {a_cl, b_cl}, 2'b00);
        chk("R6 write landed", b_bus, 16'h0F0F);
    endtask

    task automatic t_ww();
        idle(); put_a(1, 5'd7, 16'h1111, 4'hF); put_b(1, 5'd7, 16'h2222, 4'hF); tick();
        chk("R7 flags", {a_cl, b_cl}, 2'b11);
        chk("R7 writer sees old", a_bus, 16'h0F0F);
        idle(); put_a(0, 5'd7, 16'h0000, 4'h0); tick();
        chk("R7 word unchanged", a_bus, 16'h0F0F);
    endtask

    task automatic t_rr();
        idle(); put_a(0, 5'd3, 16'h0000, 4'h0); put_b(0, 5'd3, 16'h0000, 4'h0); tick();
        chk("R8 a read", a_bus, 16'h1234);
        chk("R8 b read", b_bus, 16'h1234);
        chk("R8 no flags", {a_cl, b_cl}, 2'b00);
    endtask

    task automatic t_no_collide();
        idle(); put_a(1, 5'd9, 16'h1111, 4'hF); put_b(1, 5'd10, 16'h2222, 4'hF); tick();
        chk("R10 diff addr no flags", {a_cl, b_cl}, 2'b00);
        idle(); put_a(0, 5'd10, 16'h0000, 4'h0); put_b(0, 5'd9, 16'h0000, 4'h0); tick();
        chk("R10 a sees b write", a_bus, 16'h2222);
        chk("R10 b sees a write", b_bus, 16'h1111);
        idle(); put_a(1, 5'd7, 16'h3333, 4'hF);
        b_wr = 0; b_addr = 5'd7; tick();
        chk("R10 deselected no flag", {a_cl, b_cl}, 2'b00);
    endtask

    task automatic t_group0();
        idle(); put_a(1, 5'd1, 16'h0000, 4'hF); tick();
        idle(); put_a(1, 5'd1, 16'hBEEF, 4'b0001); tick();
        chk("R4 group 0 only", a_bus, 16'h000F);
        chk("R5 whole word written", g_a_bus, 16'hBEEF);
        idle(); put_a(1, 5'd1, 16'h1234, 4'b1110); tick();
        chk("R4 upper groups", a_bus, 16'h123F);
        chk("R5 clear bit protects word", g_a_bus, 16'hBEEF);
        idle(); put_b(0, 5'd1, 16'h0000, 4'h0); tick();
        chk("R4 stored", b_bus, 16'h123F);
        chk("R5 stored", g_b_bus, 16'hBEEF);
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        report();
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_write_read();
        t_mask();
        t_idle();
        t_oe();
        t_wr_clash();
        t_ww();
        t_rr();
        t_no_collide();
        t_group0();
        report();
    end
endmodule